// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block keeps one address pointer that walks around a circular buffer. Two
bound registers hold the buffer's start and end addresses, and either one may be
the larger, so the buffer can be written in ascending or descending form. On
every update strobe the pointer moves by a signed step. If the moved pointer has
left the window between the two bounds, it is folded back in by one addition or
subtraction of the buffer length.

Software or a sequencer first loads the two bounds and then a starting pointer.
After that, one update strobe per cycle advances the pointer. The next pointer
is formed combinationally from the current pointer, the step and the bounds, and
it is captured on the strobe. The step magnitude must not exceed the buffer
length, because only one correction is applied.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset the pointer is 0x0000, both bounds are 0x0000 and the reported length is 1.
- R2: One cycle after a bounds load, `len_o` equals |end - start| + 1. This holds for start below end, start above end and start equal to end.
- R3: On an update, when pointer + step lies between the lower and the upper bound inclusive, the pointer becomes pointer + step unchanged.
- R4: On an update, when pointer + step is above the larger bound, the pointer becomes pointer + step - length (e.g. bounds 0x0200/0x020F, 0x020E + 4 gives 0x0202).
- R5: On an update, when pointer + step is below the smaller bound, the pointer becomes pointer + step + length (e.g. bounds 0x0200/0x020F, 0x0201 - 5 gives 0x020C). The sum is formed without wrapping at the address width.
- R6: Swapping start and end gives the same length and the same next pointer (e.g. start 0x0210, end 0x0201 gives length 0x10).
- R7: A pointer load sets the pointer to `ptr_val` on the next edge and takes priority over an update in the same cycle.
- R8: A bounds load leaves the pointer unchanged. An update in the same cycle as a bounds load uses the bounds that were held before that load.
- R9: With neither pointer load nor update, the pointer holds its value.
- R10: A pointer inside the buffer stays inside it after any update whose step magnitude is at most the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load both bound registers |
| cfg_start | input | AW | Start address of the buffer |
| cfg_end | input | AW | End address of the buffer |
| ptr_we | input | 1 | Load the pointer |
| ptr_val | input | AW | Pointer value to load |
| upd | input | 1 | Advance the pointer by `step` |
| step | input | AW+1 | Signed two's-complement step |
| ptr_o | output | AW | Current pointer |
| len_o | output | AW+1 | Current buffer length |

## Verification
Every cycle, the assertions check four things: the pointer holds without a strobe, a load sets it with priority, a bounds load leaves it alone, and the reported length matches the loaded bounds. They also check that a pointer starting inside the buffer stays inside after a legal step. The exact folded values can only be shown by the bench's scenarios. These cover the two worked wrap cases in both orientations, exact-boundary steps, full-length steps, a one-entry buffer, buffers at the bottom and top of the address space, and random walks compared against a modulo model.

// File: rtl/circ_pkg.sv
package circ_pkg;
  typedef enum logic [1:0] {
    FOLD_NONE = 2'd0,
    FOLD_DOWN = 2'd1,
    FOLD_UP   = 2'd2
  } fold_e;
endpackage

// File: rtl/circ_bound_regs.sv
module circ_bound_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi,
  output logic [AW:0]   len
);
  logic [AW-1:0] lo_d, hi_d;

  // order the bounds once at load time so the datapath sees low/high
  always_comb begin
    if (cfg_start <= cfg_end) begin
      lo_d = cfg_start;
      hi_d = cfg_end;
    end else begin
      lo_d = cfg_end;
      hi_d = cfg_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo  <= '0;
      hi  <= '0;
      len <= {{AW{1'b0}}, 1'b1};
    end else if (cfg_we) begin
      lo  <= lo_d;
      hi  <= hi_d;
      len <= {1'b0, hi_d} - {1'b0, lo_d} + {{AW{1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/circ_wrap_calc.sv
module circ_wrap_calc
  import circ_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW:0]   step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW:0]   len,
  output logic [AW-1:0] nxt,
  output fold_e         fold
);
  localparam int XW = AW + 2;

  logic signed [XW-1:0] sum, lo_x, hi_x, len_x, res;

  always_comb begin
    sum   = $signed({2'b00, ptr}) + $signed({step[AW], step});
    lo_x  = $signed({2'b00, lo});
    hi_x  = $signed({2'b00, hi});
    len_x = $signed({1'b0, len});
    if (sum > hi_x) begin
      fold = FOLD_DOWN;
      res  = sum - len_x;
    end else if (sum < lo_x) begin
      fold = FOLD_UP;
      res  = sum + len_x;
    end else begin
      fold = FOLD_NONE;
      res  = sum;
    end
    nxt = res[AW-1:0];
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import circ_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_val,
  input  logic          upd,
  input  logic [AW:0]   step,
  output logic [AW-1:0] ptr_o,
  output logic [AW:0]   len_o
);
  logic [AW-1:0] lo, hi, nxt;
  logic [AW:0]   len;
  fold_e         fold;

  circ_bound_regs #(.AW(AW)) u_bounds (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_start (cfg_start),
    .cfg_end   (cfg_end),
    .lo        (lo),
    .hi        (hi),
    .len       (len)
  );

  circ_wrap_calc #(.AW(AW)) u_calc (
    .ptr  (ptr_o),
    .step (step),
    .lo   (lo),
    .hi   (hi),
    .len  (len),
    .nxt  (nxt),
    .fold (fold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_o <= '0;
    else if (ptr_we) ptr_o <= ptr_val;
    else if (upd)    ptr_o <= nxt;
  end

  assign len_o = len;

  logic fold_unused;
  assign fold_unused = (fold == FOLD_NONE);
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_start,
  input logic [AW-1:0] cfg_end,
  input logic          ptr_we,
  input logic [AW-1:0] ptr_val,
  input logic          upd,
  input logic [AW:0]   step,
  input logic [AW-1:0] ptr_o,
  input logic [AW:0]   len_o
);
  logic [AW-1:0] sh_a, sh_b, sh_lo, sh_hi, win_lo, win_hi;
  logic [AW:0]   sh_len, mag;
  logic          legal_q;

  assign sh_lo  = (sh_a < sh_b) ? sh_a : sh_b;
  assign sh_hi  = (sh_a < sh_b) ? sh_b : sh_a;
  assign sh_len = {1'b0, sh_hi} - {1'b0, sh_lo} + 1'b1;
  assign mag    = step[AW] ? (~step + 1'b1) : step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a <= '0; sh_b <= '0; legal_q <= 1'b0; win_lo <= '0; win_hi <= '0;
    end else begin
      if (cfg_we) begin
        sh_a <= cfg_start;
        sh_b <= cfg_end;
      end
      legal_q <= upd && !ptr_we && (ptr_o >= sh_lo) && (ptr_o <= sh_hi)
                 && (mag <= sh_len);
      win_lo  <= sh_lo;
      win_hi  <= sh_hi;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !ptr_we) |=> $stable(ptr_o));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (ptr_o == $past(ptr_val)));

  // R8
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !upd && !ptr_we) |=> $stable(ptr_o));

  // R2
  len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_o == sh_len);

  // R10
  stay_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legal_q |-> ((ptr_o >= win_lo) && (ptr_o <= win_hi)));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/circ_addr_gen_tb.sv
module circ_addr_gen_tb;
  localparam int AW = 16;
  localparam int NV = 12;

  // columns: start, end, start pointer, step, expected next pointer
  localparam int VEC [NV][5] = '{
    '{32'h0200, 32'h020F, 32'h020E,  4, 32'h0202},  // R4
    '{32'h0200, 32'h020F, 32'h0201, -5, 32'h020C},  // R5
    '{32'h0210, 32'h0201, 32'h020F,  3, 32'h0202},  // R6 R4
    '{32'h0210, 32'h0201, 32'h0203, -4, 32'h020F},  // R6 R5
    '{32'h0200, 32'h020F, 32'h0205,  3, 32'h0208},  // R3
    '{32'h0210, 32'h0201, 32'h0208, -2, 32'h0206},  // R6 R3
    '{32'h0200, 32'h020F, 32'h020F,  1, 32'h0200},  // R4 edge
    '{32'h0200, 32'h020F, 32'h0200, -1, 32'h020F},  // R5 edge
    '{32'h0200, 32'h020F, 32'h0207, 16, 32'h0207},  // R4 full length
    '{32'h0300, 32'h0300, 32'h0300,  1, 32'h0300},  // R2 one entry
    '{32'hFFF0, 32'hFFFF, 32'hFFFE,  5, 32'hFFF3},  // R4 top of space
    '{32'h0000, 32'h000F, 32'h0001, -3, 32'h000E}   // R5 below zero
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, ptr_we = 1'b0, upd = 1'b0;
  logic [AW-1:0] cfg_start = '0, cfg_end = '0, ptr_val = '0;
  logic [AW:0]   step = '0;
  logic [AW-1:0] ptr_o;
  logic [AW:0]   len_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  circ_addr_gen #(.AW(AW)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    cfg_we = 0; ptr_we = 0; upd = 0;
  endtask

  task automatic set_bounds(input int a, input int b);
    cfg_start = a[AW-1:0]; cfg_end = b[AW-1:0]; cfg_we = 1; cyc();
  endtask

  task automatic set_ptr(input int p);
    ptr_val = p[AW-1:0]; ptr_we = 1; cyc();
  endtask

  task automatic advance(input int s);
    step = s[AW:0]; upd = 1; cyc();
  endtask

  function automatic int exp_len(input int a, input int b);
    return (a > b ? a - b : b - a) + 1;
  endfunction

  function automatic int model(input int lo, input int len, input int p, input int s);
    int off;
    off = (p - lo + s) % len;
    if (off < 0) off += len;
    return lo + off;
  endfunction

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ptr", int'(ptr_o), 0);
    check("R1 len", int'(len_o), 1);
    rst_n = 1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      set_bounds(VEC[i][0], VEC[i][1]);
      check("R2 len", int'(len_o), exp_len(VEC[i][0], VEC[i][1]));
      set_ptr(VEC[i][2]);
      check("R7 load", int'(ptr_o), VEC[i][2]);
      advance(VEC[i][3]);
      check("R3/R4/R5/R6 next", int'(ptr_o), VEC[i][4]);
    end

    // R9: idle cycles hold the pointer
    set_bounds(32'h0200, 32'h020F);
    set_ptr(32'h0204);
    step = 17'd3; cyc(); cyc();
    check("R9 hold", int'(ptr_o), 32'h0204);

    // R8: bounds load alone leaves pointer alone
    cfg_start = 16'h0400; cfg_end = 16'h0407; cfg_we = 1; cyc();
    check("R8 keep", int'(ptr_o), 32'h0204);
    check("R2 len new", int'(len_o), 8);

    // R8: update with bounds load uses old bounds 0x400..0x407
    set_ptr(32'h0406);
    cfg_start = 16'h0000; cfg_end = 16'h00FF; cfg_we = 1;
    step = 17'd3; upd = 1; cyc();
    check("R8 old bounds", int'(ptr_o), 32'h0401);
    check("R2 len after", int'(len_o), 256);

    // R7: load beats update
    ptr_val = 16'h0010; ptr_we = 1; step = 17'd5; upd = 1; cyc();
    check("R7 priority", int'(ptr_o), 32'h0010);

    // R6: reversed orientation length
    set_bounds(32'h0210, 32'h0201);
    check("R6 len", int'(len_o), 32'h10);

    // R10: random walks against a modulo model, both orientations
    for (int t = 0; t < 60; t++) begin
      int lo, len, p, a, b;
      lo  = int'($urandom_range(0, 60000));
      len = int'($urandom_range(1, 256));
      a = lo; b = lo + len - 1;
      if (t % 2 == 1) begin a = b; b = lo; end
      set_bounds(a, b);
      p = lo + int'($urandom_range(0, len - 1));
      set_ptr(p);
      for (int k = 0; k < 8; k++) begin
        int s;
        s = int'($urandom_range(0, 2 * len)) - len;
        advance(s);
        p = model(lo, len, p, s);
        check("R10 walk", int'(ptr_o), p);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule